// File: doc/BRIEF.md
# Electrical Idle Inference Timer

This block decides that the link has gone electrically idle on every lane when the traffic it expects in the normal operating state stops arriving. It watches single-cycle event pulses from the receive path: one for each received flow-control update DLLP, one for each optimized flow-control update, and one for each SKP ordered set on each lane. A configured-lane vector masks the SKP events. The block times back-to-back observation windows of 128 µs. When the rule picked by the mode input finds the awaited traffic missing for a whole window, the block raises a one-cycle indication for the link state arbiter.

The window length is a parameter counted in clock cycles. By default it is derived from the clock period, and a bench may override it with a short value. Dropping the enable input stops the timer and clears everything seen so far. The next enabled cycle starts a fresh window. The inference always covers all lanes together.

Top module: `eii_idle_infer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `idle_inferred` is 0.
- R2: With `enable` held high, windows are exactly `WINDOW_CYCLES` enabled cycles long and follow one another without gaps. A window's result appears on `idle_inferred` as a one-cycle pulse in the cycle right after the window's last cycle, and never for two cycles in a row.
- R3: Mode 0 (`mode` = 2'd0) infers idle when `fc_upd_seen` was never high during the window. A pulse in the window's last cycle still counts as received.
- R4: Mode 1 (`mode` = 2'd1) infers idle when at least one lane whose `lane_cfg` bit is 1 had no `skp_seen` pulse during the window. Lanes whose `lane_cfg` bit is 0 are ignored, and an all-zero `lane_cfg` never infers idle.
- R5: Mode 2 (`mode` = 2'd2) infers idle only when the window held no `fc_upd_seen` pulse, no `opt_fc_seen` pulse and no `skp_seen` pulse on a configured lane. A SKP pulse on an unconfigured lane does not prevent the inference.
- R6: Mode 3 (`mode` = 2'd3) never infers idle.
- R7: While `enable` is low, `idle_inferred` is 0 in the following cycle, and the window count restarts. A full window of `WINDOW_CYCLES` enabled cycles must pass after `enable` returns high before any pulse.
- R8: Traffic seen in one window does not count toward the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High while the link is in an operating state in which inference applies |
| mode | input | 2 | Inference rule: 0 flow-control, 1 per-lane SKP, 2 any traffic, 3 off |
| lane_cfg | input | NUM_LANES | One bit per lane, 1 = lane is configured |
| fc_upd_seen | input | 1 | Pulse: flow-control update DLLP received |
| opt_fc_seen | input | 1 | Pulse: optimized flow-control update received |
| skp_seen | input | NUM_LANES | Per-lane pulse: SKP ordered set received |
| idle_inferred | output | 1 | One-cycle pulse: idle inferred on all lanes |

## Verification
The only result this block produces is registered once. A window's verdict therefore shows up exactly one cycle after the edge that samples the window's last enabled cycle, and the output is low in every other cycle. The bench drives all inputs on the falling edge and samples `idle_inferred` on the next falling edge. It tracks the index of each driven cycle inside the window, so the expected pulse is due only after the cycle with index `WINDOW_CYCLES-1`, and a zero is expected after every other cycle. The sweep covers every mode, every SKP lane subset, two lane configurations and every combination of flow-control events. Each case runs as one window started by a one-cycle disable.

// File: rtl/eii_pkg.sv
// Package: shared types for the electrical idle inference timer.
// Assumes the mode input encoding is fixed as listed below.
package eii_pkg;
    typedef enum logic [1:0] {
        MODE_FC   = 2'd0,   // flow-control updates only
        MODE_SKP  = 2'd1,   // SKP on every configured lane
        MODE_ANY  = 2'd2,   // any of the three traffic kinds
        MODE_OFF  = 2'd3    // inference disabled
    } infer_mode_e;
endpackage

// File: rtl/eii_window_timer.sv
// Module: eii_window_timer
// Counts enabled cycles into windows of WINDOW_CYCLES and flags the last
// cycle of each window. Assumes WINDOW_CYCLES >= 2. The count returns to
// zero whenever enable is low.
module eii_window_timer #(
    parameter int WINDOW_CYCLES = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic win_last
);
    localparam int CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Last cycle of the current window while counting.
    assign win_last = enable && (cnt_q == LAST);

    // Advance the window position, wrapping at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (win_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r7_restart_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0));
endmodule

// File: rtl/eii_traffic_tracker.sv
// Module: eii_traffic_tracker
// Records which traffic kinds arrived in the current window. Each output
// includes the current cycle's pulse, so an event in the window's last cycle
// counts. SKP pulses are masked by the configured-lane vector. Assumes
// lane_cfg stays stable within a window.
module eii_traffic_tracker #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 win_last,
    input  logic [NUM_LANES-1:0] lane_cfg,
    input  logic                 fc_upd_seen,
    input  logic                 opt_fc_seen,
    input  logic [NUM_LANES-1:0] skp_seen,
    output logic                 fc_hit,
    output logic                 opt_hit,
    output logic [NUM_LANES-1:0] lane_hit
);
    logic                 fc_q;
    logic                 opt_q;
    logic [NUM_LANES-1:0] skp_q;

    assign fc_hit  = fc_q  | fc_upd_seen;
    assign opt_hit = opt_q | opt_fc_seen;

    // One sticky SKP flag per lane, masked by configuration.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || !enable || win_last) begin
                skp_q[g] <= 1'b0;
            end else if (skp_seen[g] && lane_cfg[g]) begin
                skp_q[g] <= 1'b1;
            end
        end
        assign lane_hit[g] = (skp_q[g] | skp_seen[g]) & lane_cfg[g];
    end

    // Sticky flow-control flags, cleared for each new window.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || win_last) begin
            fc_q  <= 1'b0;
            opt_q <= 1'b0;
        end else begin
            fc_q  <= fc_q  | fc_upd_seen;
            opt_q <= opt_q | opt_fc_seen;
        end
    end

    a_r8_fresh_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> (!fc_q && !opt_q && (skp_q == '0)));
    a_r7_flags_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!fc_q && !opt_q && (skp_q == '0)));
endmodule

// File: rtl/eii_idle_infer.sv
// Module: eii_idle_infer (top)
// Infers electrical idle on all lanes when the traffic selected by mode is
// missing for a full window, and emits a one-cycle pulse after the window.
// Assumes the event inputs are single-cycle pulses in this clock domain.
module eii_idle_infer #(
    parameter int NUM_LANES     = 4,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int WINDOW_US     = 128,
    parameter int WINDOW_CYCLES = (WINDOW_US * 1000000) / CLK_PERIOD_PS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           mode,
    input  logic [NUM_LANES-1:0] lane_cfg,
    input  logic                 fc_upd_seen,
    input  logic                 opt_fc_seen,
    input  logic [NUM_LANES-1:0] skp_seen,
    output logic                 idle_inferred
);
    import eii_pkg::*;

    logic                 win_last;
    logic                 fc_hit;
    logic                 opt_hit;
    logic [NUM_LANES-1:0] lane_hit;
    logic                 missing;
    logic                 idle_q;
    infer_mode_e          mode_e;

    assign mode_e = infer_mode_e'(mode);

    eii_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .win_last (win_last)
    );

    eii_traffic_tracker #(.NUM_LANES(NUM_LANES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .win_last    (win_last),
        .lane_cfg    (lane_cfg),
        .fc_upd_seen (fc_upd_seen),
        .opt_fc_seen (opt_fc_seen),
        .skp_seen    (skp_seen),
        .fc_hit      (fc_hit),
        .opt_hit     (opt_hit),
        .lane_hit    (lane_hit)
    );

    // Apply the selected rule to the traffic seen in this window.
    always_comb begin
        unique case (mode_e)
            MODE_FC:  missing = !fc_hit;
            MODE_SKP: missing = (lane_cfg & ~lane_hit) != '0;
            MODE_ANY: missing = !fc_hit && !opt_hit && (lane_hit == '0);
            default:  missing = 1'b0;
        endcase
    end

    // Register the verdict at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else begin
            idle_q <= win_last && missing;
        end
    end

    assign idle_inferred = idle_q;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        idle_inferred |=> !idle_inferred);
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !idle_inferred);
    a_r6_off_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> !idle_inferred);
    a_r3_fc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && fc_upd_seen) |=> !idle_inferred);
endmodule

// File: tb/eii_idle_infer_tb.sv
module eii_idle_infer_tb;
    localparam int L = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [L-1:0] lane_cfg = '1;
    logic         fc_upd_seen = 1'b0;
    logic         opt_fc_seen = 1'b0;
    logic [L-1:0] skp_seen = '0;
    logic         idle_inferred;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    eii_idle_infer #(.NUM_LANES(L), .WINDOW_CYCLES(W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .mode          (mode),
        .lane_cfg      (lane_cfg),
        .fc_upd_seen   (fc_upd_seen),
        .opt_fc_seen   (opt_fc_seen),
        .skp_seen      (skp_seen),
        .idle_inferred (idle_inferred)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: idle_inferred=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic restart();
        enable = 1'b0;
        fc_upd_seen = 1'b0; opt_fc_seen = 1'b0; skp_seen = '0;
        step();
        chk(idle_inferred, 1'b0, "R7 disabled");
    endtask

    // One full window with one stimulus pattern; verdict computed from the rules.
    task automatic run_case(input logic [1:0] m, input logic [L-1:0] cfg,
                            input logic [L-1:0] s, input bit fcv, input bit optv);
        bit miss;
        string tag;
        restart();
        mode = m; lane_cfg = cfg; enable = 1'b1;
        case (m)
            2'd0: begin miss = !fcv;                                tag = "R3 mode0"; end
            2'd1: begin miss = (cfg & ~s) != '0;                    tag = "R4 mode1"; end
            2'd2: begin miss = !fcv && !optv && ((s & cfg) == '0);  tag = "R5 mode2"; end
            default: begin miss = 1'b0;                             tag = "R6 mode3"; end
        endcase
        for (int i = 0; i < W; i++) begin
            fc_upd_seen = fcv && (i == (s[0] ? W - 1 : 0));
            opt_fc_seen = optv && (i == 3);
            skp_seen    = (i == (int'(s) % W)) ? s : '0;
            step();
            chk(idle_inferred, (i == W - 1) && miss, tag);
        end
        fc_upd_seen = 1'b0; opt_fc_seen = 1'b0; skp_seen = '0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: idle_inferred=%0b expected run to finish", idle_inferred);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            chk(idle_inferred, 1'b0, "R1 in reset");
        end
        rst_n = 1'b1;
        step();
        chk(idle_inferred, 1'b0, "R1 after reset");

        // R2: back-to-back windows, no traffic, mode 0
        mode = 2'd0; enable = 1'b1;
        for (int i = 0; i < 3 * W; i++) begin
            step();
            chk(idle_inferred, (i % W) == W - 1, "R2 window period");
        end

        // R8: traffic in window A does not carry into window B
        restart();
        enable = 1'b1;
        for (int i = 0; i < 2 * W; i++) begin
            fc_upd_seen = (i == 2);
            step();
            chk(idle_inferred, i == 2 * W - 1, "R8 fresh window");
        end
        fc_upd_seen = 1'b0;

        // R7: disabling mid-window restarts the count
        restart();
        enable = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(idle_inferred, 1'b0, "R7 before disable");
        end
        restart();
        enable = 1'b1;
        for (int i = 0; i < W; i++) begin
            step();
            chk(idle_inferred, i == W - 1, "R7 full window after enable");
        end

        // R4: no configured lanes never infers in mode 1
        run_case(2'd1, '0, '0, 1'b0, 1'b0);

        // Sweep: every mode, two lane configs, every SKP subset, fc/opt combos
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < (1 << L); s++)
                    for (int f = 0; f < 4; f++)
                        run_case(2'(m), (c == 0) ? 4'hF : 4'h5, 4'(s), f[0], f[1]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule